// File: doc/BRIEF.md
# Dual-Bank Nonvolatile Write Controller

This block sits between a single byte-wide bus and two nonvolatile arrays: a code bank (four sectors) and a data bank (two sectors plus a small emulated window). Software stages one byte by writing it to an array address. It then sets the start bit in that bank's control register. The controller holds the bank busy for a fixed number of cycles and then commits the byte to the array model. Each bank has its own read path. A read aimed at the idle bank is served normally while the other bank is programming.

Only one bank may program at a time. A start request for one bank while the other is busy is refused and flagged. When a program finishes, a per-bank pending flag is raised. That flag, gated by the bank's interrupt enable, is ORed with an external interrupt input onto one registered interrupt line. A reset during a program abandons it: the array keeps its old contents and no completion is reported, so software must issue the write again.

Top module: `nvw_ctrl`

## Requirements
- R1: After reset, the four registers read 00h and `irq` is low. The registers are: code-bank control at 224000h, data-bank control at 224001h, status at 224002h and pending at 224003h.
- R2: Array addresses decode to sectors as follows. Code bank: 000000h–000FFFh, 010000h–013FFFh, 014000h–015FFFh and 016000h–017FFFh. Data bank: 228000h–2287FFh, 22C000h–22C7FFh and 220000h–2201FFh. A programmed byte reads back at its address. A read of any other address returns 00h with `rsp_err` set, and a write to one sets the error flag.
- R3: Writing a control register with bit0 = 1 starts a program of the staged byte, which takes BUSY_CYC cycles. While the program runs, bit0 of the control register reads 1 and the bank's busy bit reads 1 in the status register (bit0 code bank, bit1 data bank). Both bits read 0 once the program ends.
- R4: A read of the idle bank while the other bank is busy returns that bank's array data with `rsp_err` low.
- R5: A read of a bank that is busy returns FFh with `rsp_err` high.
- R6: A start for one bank while the other is busy is refused. The refused bank never becomes busy, its byte is not committed, and status bit2 (error) is set.
- R7: The error flag in status bit2 is sticky. Writing 1 to bit2 clears it. Writing 0 leaves it set.
- R8: When a program ends, the bank's pending bit in the pending register is set (bit0 code bank, bit1 data bank). Writing 1 to that bit clears it.
- R9: One cycle after the inputs that determine it, `irq` equals `ext_irq` OR, for either bank, (pending AND that bank's control bit1 interrupt enable).
- R10: A reset during a program clears busy and leaves pending clear. The array keeps its previous byte.
- R11: A read request produces exactly one response, two clock edges after the edge that accepts the request.
- R12: A start with no byte staged since the bank's last start is refused. The bank does not become busy and the error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 8 | Read response data |
| rsp_err | output | 1 | Read hit a busy bank or an unmapped address |
| ext_irq | input | 1 | External interrupt request |
| irq | output | 1 | Merged interrupt output |

## Verification
The bench polls the status register on every cycle of a program. A counter that is off by one shows up as a busy bit that drops one poll early or one poll late. It starts a data-bank program while a code-bank program is running and reads both banks at that moment. A design that serialises reads would return fill data from the idle bank, and one that allows both banks to write would report both busy bits together. A reset in the middle of a program must leave the old byte in place and no pending bit set; a design that commits early, or that raises completion on abort, would return the new byte or assert the interrupt. The bench also writes 0 and then 1 to the sticky error bit, and starts a bank with nothing staged, to show that each clears or sets the flag only as specified.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] REG_BASE = 24'h224000;
  localparam logic [1:0] RSEL_CODE = 2'd0;
  localparam logic [1:0] RSEL_DATA = 2'd1;
  localparam logic [1:0] RSEL_STAT = 2'd2;
  localparam logic [1:0] RSEL_PEND = 2'd3;

  localparam logic [DATA_W-1:0] FILL_BUSY = 8'hFF;
  localparam logic [DATA_W-1:0] FILL_NONE = 8'h00;

  typedef struct packed {
    logic        code_hit;
    logic        data_hit;
    logic        reg_hit;
    logic [1:0]  sec;
    logic [11:0] off;
    logic [1:0]  rsel;
  } dec_t;

  typedef enum logic [2:0] {
    SRC_REG, SRC_CODE, SRC_DATA, SRC_FILL, SRC_NONE
  } src_t;
endpackage

// File: rtl/nvw_decode.sv
module nvw_decode
  import nvw_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  always_comb begin
    dec      = '0;
    dec.off  = addr[11:0];
    dec.rsel = addr[1:0];
    if (addr[ADDR_W-1:2] == REG_BASE[ADDR_W-1:2]) begin
      dec.reg_hit = 1'b1;
    end else if (addr <= 24'h000FFF) begin
      dec.code_hit = 1'b1; dec.sec = 2'd0;
    end else if (addr >= 24'h010000 && addr <= 24'h013FFF) begin
      dec.code_hit = 1'b1; dec.sec = 2'd1;
    end else if (addr >= 24'h014000 && addr <= 24'h015FFF) begin
      dec.code_hit = 1'b1; dec.sec = 2'd2;
    end else if (addr >= 24'h016000 && addr <= 24'h017FFF) begin
      dec.code_hit = 1'b1; dec.sec = 2'd3;
    end else if (addr >= 24'h228000 && addr <= 24'h2287FF) begin
      dec.data_hit = 1'b1; dec.sec = 2'd0;
    end else if (addr >= 24'h22C000 && addr <= 24'h22C7FF) begin
      dec.data_hit = 1'b1; dec.sec = 2'd1;
    end else if (addr >= 24'h220000 && addr <= 24'h2201FF) begin
      dec.data_hit = 1'b1; dec.sec = 2'd2;
    end
  end
endmodule

// File: rtl/nvw_bank.sv
module nvw_bank #(
  parameter int IDX_W    = 8,
  parameter int BUSY_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             start,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic             finish,
  output logic [7:0]       rd_data
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] hold_idx;
  logic [7:0]       hold_data;
  logic [7:0]       mem [DEPTH];

  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(BUSY_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en && !busy) begin
      hold_idx  <= ld_idx;
      hold_data <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (finish && !rst) mem[hold_idx] <= hold_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/nvw_ctrl.sv
module nvw_ctrl
  import nvw_pkg::*;
#(
  parameter int SEC_AW   = 6,
  parameter int BUSY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  input  logic              ext_irq,
  output logic              irq
);
  localparam int IDX_W  = SEC_AW + 2;
  localparam int NBANKS = 2;

  dec_t dec;
  logic wr, rd, unmapped;
  logic [NBANKS-1:0] bank_hit, bank_busy, bank_finish, bank_start, reject, ie_q, pend_q;
  logic [7:0]        bank_rd [NBANKS];
  logic [IDX_W-1:0]  idx;
  logic              err_q;

  nvw_decode u_dec (.addr(req_addr), .dec(dec));

  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;
  assign unmapped = !(dec.reg_hit || dec.code_hit || dec.data_hit);
  assign idx      = {dec.sec, dec.off[SEC_AW-1:0]};

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    localparam int OB = NBANKS - 1 - b;
    logic ctl_sel, go_req, staged, ie_r, pend_r;

    if (b == 0) begin : g_code
      assign bank_hit[b] = dec.code_hit;
    end else begin : g_data
      assign bank_hit[b] = dec.data_hit;
    end

    assign ctl_sel       = dec.reg_hit && (dec.rsel == 2'(b));
    assign go_req        = wr && ctl_sel && req_wdata[0] && !bank_busy[b];
    assign bank_start[b] = go_req && staged && !bank_busy[OB];
    assign reject[b]     = go_req && !bank_start[b];

    always_ff @(posedge clk) begin
      if (rst) begin
        staged <= 1'b0;
        ie_r   <= 1'b0;
        pend_r <= 1'b0;
      end else begin
        if (bank_start[b])                          staged <= 1'b0;
        else if (wr && bank_hit[b] && !bank_busy[b]) staged <= 1'b1;
        if (wr && ctl_sel) ie_r <= req_wdata[1];
        if (bank_finish[b]) pend_r <= 1'b1;
        else if (wr && dec.reg_hit && dec.rsel == RSEL_PEND && req_wdata[b]) pend_r <= 1'b0;
      end
    end

    assign ie_q[b]   = ie_r;
    assign pend_q[b] = pend_r;

    nvw_bank #(.IDX_W(IDX_W), .BUSY_CYC(BUSY_CYC)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .ld_en  (wr && bank_hit[b]),
      .ld_idx (idx),
      .ld_data(req_wdata),
      .start  (bank_start[b]),
      .rd_idx (idx),
      .busy   (bank_busy[b]),
      .finish (bank_finish[b]),
      .rd_data(bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if (|reject || (wr && unmapped)) err_q <= 1'b1;
    else if (wr && dec.reg_hit && dec.rsel == RSEL_STAT && req_wdata[2]) err_q <= 1'b0;
  end

  // register read value, picked at request time
  logic [7:0] reg_val;
  always_comb begin
    case (dec.rsel)
      RSEL_CODE: reg_val = {6'b0, ie_q[0], bank_busy[0]};
      RSEL_DATA: reg_val = {6'b0, ie_q[1], bank_busy[1]};
      RSEL_STAT: reg_val = {5'b0, err_q, bank_busy[1], bank_busy[0]};
      default:   reg_val = {6'b0, pend_q};
    endcase
  end

  // read pipeline: stage 1 aligns with the array's registered read
  logic       s1_valid;
  src_t       s1_src;
  logic [7:0] s1_reg;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_src   <= SRC_NONE;
      s1_reg   <= '0;
    end else begin
      s1_valid <= rd;
      s1_reg   <= reg_val;
      if (dec.reg_hit)                      s1_src <= SRC_REG;
      else if (|(bank_hit & bank_busy))     s1_src <= SRC_FILL;
      else if (dec.code_hit)                s1_src <= SRC_CODE;
      else if (dec.data_hit)                s1_src <= SRC_DATA;
      else                                  s1_src <= SRC_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_err   <= s1_valid && (s1_src == SRC_FILL || s1_src == SRC_NONE);
      case (s1_src)
        SRC_REG:  rsp_data <= s1_reg;
        SRC_CODE: rsp_data <= bank_rd[0];
        SRC_DATA: rsp_data <= bank_rd[1];
        SRC_FILL: rsp_data <= FILL_BUSY;
        default:  rsp_data <= FILL_NONE;
      endcase
      irq <= ext_irq || |(pend_q & ie_q);
    end
  end
endmodule

// File: rtl/nvw_ctrl_chk.sv
module nvw_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [23:0] req_addr,
  input logic [7:0]  req_wdata,
  input logic        rsp_valid,
  input logic [7:0]  rsp_data,
  input logic        rsp_err,
  input logic        ext_irq,
  input logic        irq,
  input logic [1:0]  bank_busy,
  input logic [1:0]  bank_hit,
  input logic [1:0]  pend_q,
  input logic        err_q
);
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(bank_busy[0] && bank_busy[1])); // R6

  AST_BUSY_FILL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && |(bank_hit & bank_busy))
      |=> ##1 (rsp_valid && rsp_err && rsp_data == 8'hFF)); // R5

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> ##1 rsp_valid); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(req_valid && req_write && req_addr == 24'h224002 && req_wdata[2]))
      |=> err_q); // R7

  AST_EXT_IRQ: assert property (@(posedge clk) disable iff (rst)
    ext_irq |=> irq); // R9

  AST_RST_ABORT: assert property (@(posedge clk)
    rst |=> (bank_busy == 2'b00 && pend_q == 2'b00)); // R10
endmodule

bind nvw_ctrl nvw_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .rsp_err(rsp_err), .ext_irq(ext_irq), .irq(irq),
  .bank_busy(bank_busy), .bank_hit(bank_hit), .pend_q(pend_q), .err_q(err_q)
);

// File: tb/sim_nvw_ctrl.sv
`timescale 1ns/1ps
module sim_nvw_ctrl;
  localparam int BUSY = 16;
  localparam logic [23:0] A_CCTL = 24'h224000, A_DCTL = 24'h224001,
                          A_STAT = 24'h224002, A_PEND = 24'h224003;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, ext_irq = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic rsp_valid, rsp_err, irq;
  logic [7:0] rsp_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] q_d[$];
  logic       q_e[$];
  int         q_due[$];
  string      q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvw_ctrl #(.SEC_AW(6), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .ext_irq(ext_irq), .irq(irq));

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(logic [23:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic get(logic [23:0] a, logic [7:0] d, logic e, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    q_d.push_back(d); q_e.push_back(e); q_due.push_back(cyc + 2); q_tag.push_back(tag);
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected responses as the design produces them
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_d.size() == 0) begin
        check("R11 unexpected response", {rsp_err, rsp_data}, 9'h1FF);
      end else begin
        logic [7:0] d; logic e; int due; string t;
        d = q_d.pop_front(); e = q_e.pop_front(); due = q_due.pop_front(); t = q_tag.pop_front();
        check(t, {rsp_err, rsp_data}, {e, d});
        check("R11 latency", 9'(cyc), 9'(due));
      end
    end
  end

  task automatic report;
    if (q_d.size() != 0) check("R11 missing response", 9'(q_d.size()), 9'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", {8'b0, irq}, 9'd0);
    get(A_CCTL, 8'h00, 1'b0, "R1 code ctl");
    get(A_DCTL, 8'h00, 1'b0, "R1 data ctl");
    get(A_STAT, 8'h00, 1'b0, "R1 status");
    get(A_PEND, 8'h00, 1'b0, "R1 pending");
    get(24'h300000, 8'h00, 1'b1, "R2 unmapped read");

    // R3 busy window polled every cycle, data bank with interrupt enabled
    put(24'h228010, 8'h5A);
    put(A_DCTL, 8'h03);
    for (int k = 1; k <= BUSY; k++) get(A_STAT, 8'h02, 1'b0, "R3 busy poll");
    get(A_STAT, 8'h00, 1'b0, "R3 busy cleared");
    get(A_PEND, 8'h02, 1'b0, "R8 pending set");
    idle(3);
    check("R9 irq from pending", {8'b0, irq}, 9'd1);
    put(A_PEND, 8'h02);
    idle(2);
    check("R9 irq after clear", {8'b0, irq}, 9'd0);
    get(A_PEND, 8'h00, 1'b0, "R8 pending cleared");
    @(negedge clk) ext_irq = 1'b1;
    idle(2);
    check("R9 ext irq", {8'b0, irq}, 9'd1);
    ext_irq = 1'b0;
    idle(2);
    check("R9 ext irq released", {8'b0, irq}, 9'd0);

    // R2 read back across sectors
    get(24'h228010, 8'h5A, 1'b0, "R2 data sector 0");
    put(24'h014003, 8'hC3); put(A_CCTL, 8'h01); idle(BUSY + 3);
    put(24'h2201F0, 8'h3C); put(A_DCTL, 8'h01); idle(BUSY + 3);
    get(24'h014003, 8'hC3, 1'b0, "R2 code sector 2");
    get(24'h2201F0, 8'h3C, 1'b0, "R2 emulated window");
    get(24'h228010, 8'h5A, 1'b0, "R2 data sector 0 kept");

    // R6 conflict, R4 cross-bank read, R5 busy-bank read
    put(24'h000020, 8'h77);
    put(A_CCTL, 8'h01);
    put(24'h22C010, 8'h99);
    put(A_DCTL, 8'h01);
    get(A_STAT, 8'h05, 1'b0, "R6 conflict flagged");
    get(24'h228010, 8'h5A, 1'b0, "R4 idle bank read");
    get(24'h000020, 8'hFF, 1'b1, "R5 busy bank read");
    get(A_DCTL, 8'h00, 1'b0, "R6 refused bank idle");
    get(A_CCTL, 8'h01, 1'b0, "R3 ctl busy bit");
    idle(BUSY + 3);
    get(A_STAT, 8'h04, 1'b0, "R6 error kept");
    get(24'h000020, 8'h77, 1'b0, "R2 code sector 0");

    // R7 sticky error
    put(A_STAT, 8'h00);
    get(A_STAT, 8'h04, 1'b0, "R7 write 0 keeps");
    put(A_STAT, 8'h04);
    get(A_STAT, 8'h00, 1'b0, "R7 write 1 clears");
    put(24'h300000, 8'h12);
    get(A_STAT, 8'h04, 1'b0, "R2 unmapped write error");
    put(A_STAT, 8'h04);

    // R12 start without staged byte
    put(A_CCTL, 8'h01);
    get(A_STAT, 8'h04, 1'b0, "R12 refused start");
    get(A_CCTL, 8'h00, 1'b0, "R12 not busy");
    put(A_STAT, 8'h04);

    // R10 reset mid-program
    put(24'h000020, 8'h22);
    put(A_CCTL, 8'h03);
    idle(5);
    @(negedge clk) rst = 1'b1;
    idle(2);
    rst = 1'b0;
    get(A_STAT, 8'h00, 1'b0, "R10 busy cleared");
    get(A_PEND, 8'h00, 1'b0, "R10 no pending");
    get(24'h000020, 8'h77, 1'b0, "R10 old byte kept");
    idle(BUSY + 3);
    check("R10 no irq", {8'b0, irq}, 9'd0);
    get(24'h000020, 8'h77, 1'b0, "R10 still old byte");
    idle(5);
    report();
  end
endmodule